// File: doc/BRIEF.md
# Rule-based stack-operation folding unit

This unit sits in the decode stage of a single-pipeline stack machine. Each cycle it looks at a window of pre-decoded bytecode descriptors taken from the head of the instruction buffer. It merges a run of neighbouring stack operations into one register-style instruction with explicit source and destination operands. Every descriptor carries a class. The class is Producer (pushes a constant or a local), Operator (pops, computes and pushes), Consumer (pops and stores) or non-foldable (branch, call, object operation). Each descriptor also carries an operator pop count, a data type, a double-width flag and an operand field.

Folding is decided one step at a time. The running group is compared with the next descriptor, and the pair either merges into a new group with a combined class or the group ends. A group ends when it completes, when the types or widths differ, when no rule applies, when the configured size cap is reached, or when the window runs out of valid entries. The finished group is registered and issued together with the number of original bytecodes it used, so that the buffer can move its head pointer forward by that amount.

Top module: `poc_fold_unit`

## Requirements
- R1: Descriptor class codes are 0 Producer, 1 Operator, 2 Consumer, 3 non-foldable. The same codes appear on `issue_cls_o`, where 2 also marks a completed group. The first valid entry opens the group. A Producer places its operand in source 0, and an Operator places its operand in the op field.
- R2: A Producer followed by a Producer stays a Producer group, and the second operand goes to source 1. A group never holds more than two producers, so a third Producer ends it.
- R3: A Producer group followed by an Operator becomes an Operator group when the Operator's pop count is at least the number of grouped producers. Otherwise the group ends. An Operator group followed by anything other than a Consumer ends.
- R4: An Operator group followed by a Consumer, or a single-producer group followed by a Consumer (a move), completes the group. The result has class 2, the destination is valid and carries the Consumer's operand, and the group ends. A two-producer group followed by a Consumer ends without merging.
- R5: A next entry whose type code or double-width flag differs from the group's ends the group. Double-width entries fold with each other under the same rules.
- R6: A non-foldable entry or a leading Consumer issues alone with a count of 1. A non-foldable entry is never merged into an open group.
- R7: `fold_lim_i` caps the group size: 0 gives 2, 1 gives 3, and 2 or 3 give 4 bytecodes.
- R8: An invalid window entry ends the group, and the partial group issues as it stands. An invalid entry 0 gives no issue in the next cycle.
- R9: The result appears on the outputs one clock edge after the window is presented. During reset, and in any cycle without an issue, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fold_lim_i | input | 2 | Group size cap code |
| win_vld_i | input | WIN | Entry valid, entry 0 is the buffer head |
| win_cls_i | input | 2*WIN | Entry class code |
| win_npop_i | input | 2*WIN | Operator pop count |
| win_wide_i | input | WIN | Double-width flag |
| win_typ_i | input | 2*WIN | Data type code |
| win_opnd_i | input | 8*WIN | Operand field (index, constant or opcode) |
| issue_vld_o | output | 1 | Folded instruction valid |
| issue_cls_o | output | 2 | Combined class of the issued group |
| issue_cnt_o | output | 3 | Bytecodes consumed |
| src_vld_o | output | 2 | Source 1 and source 0 valid |
| src0_o | output | 8 | First producer operand |
| src1_o | output | 8 | Second producer operand |
| op_o | output | 8 | Operator or non-foldable operand |
| dst_vld_o | output | 1 | Destination valid |
| dst_o | output | 8 | Consumer operand |

## Verification
The assertions check the output invariants on every cycle. The consumed count never exceeds the cap that was in force. A non-foldable issue always consumes one bytecode, and a valid destination only comes with a completed group. Two valid sources imply at least two bytecodes, an empty head produces no issue, and idle outputs stay zero. Only the bench's scenarios can show that each pairwise rule fires on the right neighbour and stops on the wrong one. These include the pop-count fit, the two-producer limit, type and width mismatches, the cap codes and window exhaustion, along with the exact operands routed into each field.

// File: rtl/poc_fold_pkg.sv
`timescale 1ns/1ps
package poc_fold_pkg;
  localparam int OPND_W   = 8;
  localparam int MAX_FOLD = 4;
  localparam int CNT_W    = $clog2(MAX_FOLD + 1);

  typedef enum logic [1:0] {
    CLS_PROD   = 2'd0,
    CLS_OPER   = 2'd1,
    CLS_CONS   = 2'd2,
    CLS_NOFOLD = 2'd3
  } poc_cls_e;

  typedef struct packed {
    logic              vld;
    poc_cls_e          cls;
    logic [1:0]        npop;
    logic              wide;
    logic [1:0]        typ;
    logic [OPND_W-1:0] opnd;
  } bc_desc_t;

  typedef struct packed {
    poc_cls_e          cls;
    logic [1:0]        nprod;
    logic              wide;
    logic [1:0]        typ;
    logic              done;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        srcv;
    logic [OPND_W-1:0] src0;
    logic [OPND_W-1:0] src1;
    logic [OPND_W-1:0] op;
    logic              dstv;
    logic [OPND_W-1:0] dst;
  } grp_t;

  typedef struct packed {
    poc_cls_e          cls;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        srcv;
    logic [OPND_W-1:0] src0;
    logic [OPND_W-1:0] src1;
    logic [OPND_W-1:0] op;
    logic              dstv;
    logic [OPND_W-1:0] dst;
  } issue_t;
endpackage

// File: rtl/poc_fold_seed.sv
`timescale 1ns/1ps
module poc_fold_seed
  import poc_fold_pkg::*;
(
  input  bc_desc_t d_i,
  output grp_t     g_o
);
  logic unused_seed;
  assign unused_seed = ^{d_i.vld, d_i.npop};

  always_comb begin
    g_o       = '0;
    g_o.cls   = d_i.cls;
    g_o.wide  = d_i.wide;
    g_o.typ   = d_i.typ;
    g_o.cnt   = CNT_W'(1);
    case (d_i.cls)
      CLS_PROD: begin
        g_o.src0  = d_i.opnd;
        g_o.srcv  = 2'b01;
        g_o.nprod = 2'd1;
      end
      CLS_OPER: g_o.op = d_i.opnd;
      CLS_CONS: begin
        g_o.dst  = d_i.opnd;
        g_o.dstv = 1'b1;
        g_o.done = 1'b1;
      end
      default: begin
        g_o.op   = d_i.opnd;
        g_o.done = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/poc_fold_step.sv
`timescale 1ns/1ps
module poc_fold_step
  import poc_fold_pkg::*;
(
  input  grp_t             g_i,
  input  bc_desc_t         nxt_i,
  input  logic [CNT_W-1:0] max_i,
  output grp_t             g_o
);
  logic rule_ok;
  logic take;

  // pairwise class rules
  always_comb begin
    rule_ok = 1'b0;
    case (g_i.cls)
      CLS_PROD: begin
        case (nxt_i.cls)
          CLS_PROD: rule_ok = (g_i.nprod < 2'd2);
          CLS_OPER: rule_ok = (nxt_i.npop >= g_i.nprod);
          CLS_CONS: rule_ok = (g_i.nprod == 2'd1);
          default:  rule_ok = 1'b0;
        endcase
      end
      CLS_OPER: rule_ok = (nxt_i.cls == CLS_CONS);
      default:  rule_ok = 1'b0;
    endcase
  end

  assign take = !g_i.done && nxt_i.vld && (g_i.cnt < max_i) &&
                (nxt_i.wide == g_i.wide) && (nxt_i.typ == g_i.typ) && rule_ok;

  always_comb begin
    g_o = g_i;
    if (take) begin
      g_o.cnt = g_i.cnt + CNT_W'(1);
      case (nxt_i.cls)
        CLS_PROD: begin
          g_o.src1  = nxt_i.opnd;
          g_o.srcv  = 2'b11;
          g_o.nprod = g_i.nprod + 2'd1;
        end
        CLS_OPER: begin
          g_o.cls = CLS_OPER;
          g_o.op  = nxt_i.opnd;
        end
        default: begin
          g_o.cls  = CLS_CONS;
          g_o.dst  = nxt_i.opnd;
          g_o.dstv = 1'b1;
          g_o.done = 1'b1;
        end
      endcase
    end else begin
      g_o.done = 1'b1;
    end
  end
endmodule

// File: rtl/poc_fold_issue.sv
`timescale 1ns/1ps
module poc_fold_issue
  import poc_fold_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   vld_i,
  input  issue_t d_i,
  output logic   vld_o,
  output issue_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else begin
      vld_o <= vld_i;
      q_o   <= vld_i ? d_i : '0;
    end
  end
endmodule

// File: rtl/poc_fold_unit.sv
`timescale 1ns/1ps
module poc_fold_unit
  import poc_fold_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            fold_lim_i,
  input  logic [WIN-1:0]        win_vld_i,
  input  logic [2*WIN-1:0]      win_cls_i,
  input  logic [2*WIN-1:0]      win_npop_i,
  input  logic [WIN-1:0]        win_wide_i,
  input  logic [2*WIN-1:0]      win_typ_i,
  input  logic [OPND_W*WIN-1:0] win_opnd_i,
  output logic                  issue_vld_o,
  output logic [1:0]            issue_cls_o,
  output logic [CNT_W-1:0]      issue_cnt_o,
  output logic [1:0]            src_vld_o,
  output logic [OPND_W-1:0]     src0_o,
  output logic [OPND_W-1:0]     src1_o,
  output logic [OPND_W-1:0]     op_o,
  output logic                  dst_vld_o,
  output logic [OPND_W-1:0]     dst_o
);
  bc_desc_t         desc  [WIN];
  grp_t             chain [WIN];
  grp_t             fin;
  issue_t           iss_d;
  issue_t           iss_q;
  logic [CNT_W-1:0] lim_max;
  logic             unused_fin;

  always_comb begin
    case (fold_lim_i)
      2'd0:    lim_max = CNT_W'(2);
      2'd1:    lim_max = CNT_W'(3);
      default: lim_max = CNT_W'(4);
    endcase
  end

  for (genvar k = 0; k < WIN; k++) begin : gen_unpack
    assign desc[k].vld  = win_vld_i[k];
    assign desc[k].cls  = poc_cls_e'(win_cls_i[2*k +: 2]);
    assign desc[k].npop = win_npop_i[2*k +: 2];
    assign desc[k].wide = win_wide_i[k];
    assign desc[k].typ  = win_typ_i[2*k +: 2];
    assign desc[k].opnd = win_opnd_i[OPND_W*k +: OPND_W];
  end

  poc_fold_seed u_seed (
    .d_i (desc[0]),
    .g_o (chain[0])
  );

  for (genvar k = 1; k < WIN; k++) begin : gen_step
    poc_fold_step u_step (
      .g_i   (chain[k-1]),
      .nxt_i (desc[k]),
      .max_i (lim_max),
      .g_o   (chain[k])
    );
  end

  assign fin        = chain[WIN-1];
  assign unused_fin = ^{fin.nprod, fin.wide, fin.typ, fin.done};

  assign iss_d = '{cls: fin.cls, cnt: fin.cnt, srcv: fin.srcv, src0: fin.src0,
                   src1: fin.src1, op: fin.op, dstv: fin.dstv, dst: fin.dst};

  poc_fold_issue u_issue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (win_vld_i[0]),
    .d_i    (iss_d),
    .vld_o  (issue_vld_o),
    .q_o    (iss_q)
  );

  assign issue_cls_o = iss_q.cls;
  assign issue_cnt_o = iss_q.cnt;
  assign src_vld_o   = iss_q.srcv;
  assign src0_o      = iss_q.src0;
  assign src1_o      = iss_q.src1;
  assign op_o        = iss_q.op;
  assign dst_vld_o   = iss_q.dstv;
  assign dst_o       = iss_q.dst;
endmodule

// File: rtl/poc_fold_chk.sv
`timescale 1ns/1ps
module poc_fold_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] fold_lim_i,
  input logic       head_vld_i,
  input logic       issue_vld_o,
  input logic [1:0] issue_cls_o,
  input logic [2:0] issue_cnt_o,
  input logic [1:0] src_vld_o,
  input logic       dst_vld_o
);
  function automatic logic [2:0] cap_of(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  AST_CNT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_vld_o |-> (issue_cnt_o >= 3'd1 && issue_cnt_o <= cap_of($past(fold_lim_i)))); // R7
  AST_EMPTY_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_vld_i |=> !issue_vld_o); // R8
  AST_NOFOLD_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_vld_o && issue_cls_o == 2'd3) |-> issue_cnt_o == 3'd1); // R6
  AST_DST_COMPLETE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_vld_o && dst_vld_o) |-> issue_cls_o == 2'd2); // R4
  AST_TWO_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_vld_o && src_vld_o == 2'b11) |-> issue_cnt_o >= 3'd2); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_vld_o |-> (issue_cnt_o == 3'd0 && !dst_vld_o && src_vld_o == 2'b00)); // R9
endmodule

bind poc_fold_unit poc_fold_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fold_lim_i  (fold_lim_i),
  .head_vld_i  (win_vld_i[0]),
  .issue_vld_o (issue_vld_o),
  .issue_cls_o (issue_cls_o),
  .issue_cnt_o (issue_cnt_o),
  .src_vld_o   (src_vld_o),
  .dst_vld_o   (dst_vld_o)
);

// File: tb/poc_fold_unit_tb_top.sv
`timescale 1ns/1ps
module poc_fold_unit_tb_top;
  localparam int WIN = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  fold_lim_i = '0;
  logic [3:0]  win_vld_i = '0;
  logic [7:0]  win_cls_i = '0;
  logic [7:0]  win_npop_i = '0;
  logic [3:0]  win_wide_i = '0;
  logic [7:0]  win_typ_i = '0;
  logic [31:0] win_opnd_i = '0;
  logic        issue_vld_o;
  logic [1:0]  issue_cls_o;
  logic [2:0]  issue_cnt_o;
  logic [1:0]  src_vld_o;
  logic [7:0]  src0_o, src1_o, op_o, dst_o;
  logic        dst_vld_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  poc_fold_unit #(.WIN(WIN)) dut_i (.*);

  // entry: {vld, cls, npop, wide, typ, opnd}
  function automatic logic [15:0] ent(input logic v, input logic [1:0] c, input logic [1:0] n,
                                      input logic w, input logic [1:0] t, input logic [7:0] o);
    return {v, c, n, w, t, o};
  endfunction

  typedef struct packed {
    logic [1:0]  lim;
    logic [63:0] w;
    logic        ev;
    logic [1:0]  ecls;
    logic [2:0]  ecnt;
    logic [1:0]  esrcv;
    logic        edstv;
    logic [7:0]  eop;
    logic [7:0]  edst;
    logic [7:0]  es0;
    logic [7:0]  es1;
  } vec_t;

  function automatic vec_t mkv(input logic [1:0] lim, input logic [15:0] e0, input logic [15:0] e1,
                               input logic [15:0] e2, input logic [15:0] e3, input logic ev,
                               input logic [1:0] ecls, input logic [2:0] ecnt, input logic [1:0] esrcv,
                               input logic edstv, input logic [7:0] eop, input logic [7:0] edst,
                               input logic [7:0] es0, input logic [7:0] es1);
    return '{lim: lim, w: {e3, e2, e1, e0}, ev: ev, ecls: ecls, ecnt: ecnt, esrcv: esrcv,
             edstv: edstv, eop: eop, edst: edst, es0: es0, es1: es1};
  endfunction

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    // 0 R1 R2 R3 R4: P P O C fully folded
    mkv(2'd2, ent(1,0,0,0,0,8'h05), ent(1,0,0,0,0,8'h06), ent(1,1,2,0,0,8'h60), ent(1,2,0,0,0,8'h09),
        1, 2'd2, 3'd4, 2'b11, 1, 8'h60, 8'h09, 8'h05, 8'h06),
    // 1 R2: third producer ends
    mkv(2'd2, ent(1,0,0,0,0,8'h01), ent(1,0,0,0,0,8'h02), ent(1,0,0,0,0,8'h03), ent(1,1,2,0,0,8'h60),
        1, 2'd0, 3'd2, 2'b11, 0, 8'h00, 8'h00, 8'h01, 8'h02),
    // 2 R3 R6: P O then non-foldable ends
    mkv(2'd2, ent(1,0,0,0,0,8'h01), ent(1,1,1,0,0,8'h21), ent(1,3,0,0,0,8'h00), ent(1,3,0,0,0,8'h00),
        1, 2'd1, 3'd2, 2'b01, 0, 8'h21, 8'h00, 8'h01, 8'h00),
    // 3 R3: pop count 1 below two producers
    mkv(2'd2, ent(1,0,0,0,0,8'h01), ent(1,0,0,0,0,8'h02), ent(1,1,1,0,0,8'h22), ent(1,2,0,0,0,8'h09),
        1, 2'd0, 3'd2, 2'b11, 0, 8'h00, 8'h00, 8'h01, 8'h02),
    // 4 R4: move P C
    mkv(2'd2, ent(1,0,0,0,0,8'h03), ent(1,2,0,0,0,8'h07), ent(1,0,0,0,0,8'h01), ent(1,0,0,0,0,8'h01),
        1, 2'd2, 3'd2, 2'b01, 1, 8'h00, 8'h07, 8'h03, 8'h00),
    // 5 R4: two producers then consumer does not merge
    mkv(2'd2, ent(1,0,0,0,0,8'h01), ent(1,0,0,0,0,8'h02), ent(1,2,0,0,0,8'h08), 16'h0,
        1, 2'd0, 3'd2, 2'b11, 0, 8'h00, 8'h00, 8'h01, 8'h02),
    // 6 R5: type mismatch
    mkv(2'd2, ent(1,0,0,0,0,8'h01), ent(1,0,0,0,1,8'h02), ent(1,2,0,0,1,8'h08), 16'h0,
        1, 2'd0, 3'd1, 2'b01, 0, 8'h00, 8'h00, 8'h01, 8'h00),
    // 7 R5: wide P O then narrow C ends
    mkv(2'd2, ent(1,0,0,1,0,8'h01), ent(1,1,1,1,0,8'h31), ent(1,2,0,0,0,8'h09), 16'h0,
        1, 2'd1, 3'd2, 2'b01, 0, 8'h31, 8'h00, 8'h01, 8'h00),
    // 8 R5: wide move
    mkv(2'd2, ent(1,0,0,1,0,8'h01), ent(1,2,0,1,0,8'h0a), 16'h0, 16'h0,
        1, 2'd2, 3'd2, 2'b01, 1, 8'h00, 8'h0a, 8'h01, 8'h00),
    // 9 R6: non-foldable alone
    mkv(2'd2, ent(1,3,0,0,0,8'h44), ent(1,0,0,0,0,8'h01), ent(1,0,0,0,0,8'h02), 16'h0,
        1, 2'd3, 3'd1, 2'b00, 0, 8'h44, 8'h00, 8'h00, 8'h00),
    // 10 R6: leading consumer alone
    mkv(2'd2, ent(1,2,0,0,0,8'h12), ent(1,0,0,0,0,8'h01), 16'h0, 16'h0,
        1, 2'd2, 3'd1, 2'b00, 1, 8'h00, 8'h12, 8'h00, 8'h00),
    // 11 R6: non-foldable not merged into group
    mkv(2'd2, ent(1,0,0,0,0,8'h01), ent(1,3,0,0,0,8'h55), 16'h0, 16'h0,
        1, 2'd0, 3'd1, 2'b01, 0, 8'h00, 8'h00, 8'h01, 8'h00),
    // 12 R7: cap 2
    mkv(2'd0, ent(1,0,0,0,0,8'h01), ent(1,0,0,0,0,8'h02), ent(1,1,2,0,0,8'h60), ent(1,2,0,0,0,8'h09),
        1, 2'd0, 3'd2, 2'b11, 0, 8'h00, 8'h00, 8'h01, 8'h02),
    // 13 R7: cap 3
    mkv(2'd1, ent(1,0,0,0,0,8'h01), ent(1,0,0,0,0,8'h02), ent(1,1,2,0,0,8'h60), ent(1,2,0,0,0,8'h09),
        1, 2'd1, 3'd3, 2'b11, 0, 8'h60, 8'h00, 8'h01, 8'h02),
    // 14 R7: code 3 caps at 4
    mkv(2'd3, ent(1,0,0,0,0,8'h01), ent(1,0,0,0,0,8'h02), ent(1,1,2,0,0,8'h60), ent(1,2,0,0,0,8'h09),
        1, 2'd2, 3'd4, 2'b11, 1, 8'h60, 8'h09, 8'h01, 8'h02),
    // 15 R8: window runs out after two
    mkv(2'd2, ent(1,0,0,0,0,8'h01), ent(1,0,0,0,0,8'h02), 16'h0, 16'h0,
        1, 2'd0, 3'd2, 2'b11, 0, 8'h00, 8'h00, 8'h01, 8'h02),
    // 16 R1 R4: leading operator then consumer
    mkv(2'd2, ent(1,1,2,0,0,8'h61), ent(1,2,0,0,0,8'h0b), 16'h0, 16'h0,
        1, 2'd2, 3'd2, 2'b00, 1, 8'h61, 8'h0b, 8'h00, 8'h00),
    // 17 R8 R9: empty head, no issue, zero outputs
    mkv(2'd2, 16'h0, ent(1,0,0,0,0,8'h01), ent(1,0,0,0,0,8'h02), 16'h0,
        0, 2'd0, 3'd0, 2'b00, 0, 8'h00, 8'h00, 8'h00, 8'h00),
    // 18 R8: hole at entry 1 stops folding
    mkv(2'd2, ent(1,0,0,0,0,8'h01), 16'h0, ent(1,1,1,0,0,8'h22), ent(1,2,0,0,0,8'h09),
        1, 2'd0, 3'd1, 2'b01, 0, 8'h00, 8'h00, 8'h01, 8'h00),
    // 19 R3: pop count 2 over one producer fits
    mkv(2'd2, ent(1,0,0,0,0,8'h04), ent(1,1,2,0,0,8'h62), ent(1,2,0,0,0,8'h0c), ent(1,0,0,0,0,8'h01),
        1, 2'd2, 3'd3, 2'b01, 1, 8'h62, 8'h0c, 8'h04, 8'h00),
    // 20 R3: operator followed by producer ends
    mkv(2'd2, ent(1,1,1,0,0,8'h63), ent(1,0,0,0,0,8'h01), 16'h0, 16'h0,
        1, 2'd1, 3'd1, 2'b00, 0, 8'h63, 8'h00, 8'h00, 8'h00)
  };

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", msg, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    fold_lim_i = v.lim;
    for (int k = 0; k < WIN; k++) begin
      win_vld_i[k]          = v.w[16*k+15];
      win_cls_i[2*k +: 2]   = v.w[16*k+13 +: 2];
      win_npop_i[2*k +: 2]  = v.w[16*k+11 +: 2];
      win_wide_i[k]         = v.w[16*k+10];
      win_typ_i[2*k +: 2]   = v.w[16*k+8 +: 2];
      win_opnd_i[8*k +: 8]  = v.w[16*k +: 8];
    end
  endtask

  task automatic clear_win();
    win_vld_i = '0; win_cls_i = '0; win_npop_i = '0;
    win_wide_i = '0; win_typ_i = '0; win_opnd_i = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    clear_win();
    repeat (2) @(negedge clk_i);
    // R9 reset state
    chk(!issue_vld_o, "R9 reset vld", int'(issue_vld_o), 0);
    chk(issue_cnt_o == 3'd0 && src_vld_o == 2'b00 && !dst_vld_o, "R9 reset fields",
        int'(issue_cnt_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(posedge clk_i);
      @(negedge clk_i);
      chk(issue_vld_o == VECS[i].ev, $sformatf("vec%0d vld", i), int'(issue_vld_o), int'(VECS[i].ev));
      chk(issue_cnt_o == VECS[i].ecnt, $sformatf("vec%0d cnt", i), int'(issue_cnt_o), int'(VECS[i].ecnt));
      chk(issue_cls_o == VECS[i].ecls, $sformatf("vec%0d cls", i), int'(issue_cls_o), int'(VECS[i].ecls));
      chk(src_vld_o == VECS[i].esrcv, $sformatf("vec%0d srcv", i), int'(src_vld_o), int'(VECS[i].esrcv));
      chk(dst_vld_o == VECS[i].edstv, $sformatf("vec%0d dstv", i), int'(dst_vld_o), int'(VECS[i].edstv));
      chk(op_o == VECS[i].eop, $sformatf("vec%0d op", i), int'(op_o), int'(VECS[i].eop));
      chk(dst_o == VECS[i].edst, $sformatf("vec%0d dst", i), int'(dst_o), int'(VECS[i].edst));
      chk(src0_o == VECS[i].es0, $sformatf("vec%0d src0", i), int'(src0_o), int'(VECS[i].es0));
      chk(src1_o == VECS[i].es1, $sformatf("vec%0d src1", i), int'(src1_o), int'(VECS[i].es1));
    end

    // R9: output holds until the next edge
    drive(VECS[0]);
    @(posedge clk_i);
    @(negedge clk_i);
    clear_win();
    #1;
    chk(issue_vld_o && issue_cnt_o == 3'd4, "R9 hold before edge", int'(issue_cnt_o), 4);
    // R8: empty window gives no issue
    @(posedge clk_i);
    @(negedge clk_i);
    chk(!issue_vld_o && issue_cnt_o == 3'd0, "R8 empty window", int'(issue_vld_o), 0);

    // R9: asynchronous reset clears a pending issue
    drive(VECS[4]);
    @(posedge clk_i);
    #1;
    chk(issue_vld_o, "R9 issue before reset", int'(issue_vld_o), 1);
    rst_ni = 1'b0;
    #0.5;
    chk(!issue_vld_o && !dst_vld_o, "R9 async reset", int'(issue_vld_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    clear_win();
    @(posedge clk_i);
    @(negedge clk_i);

    finish_run();
  end
endmodule